// File: doc/BRIEF.md
# Map-Table Register Renamer

This block gives each architectural register write its own physical register, so that later writes to the same name no longer conflict with earlier reads or writes of that name. Dependences where one instruction reads another's result stay intact. A table holds, for every architectural name, the physical register of its newest write. A queue holds the physical registers that are not in use. Each cycle one instruction can be renamed. Its two source names are looked up in the table, and its destination, when it has one, takes the physical register at the head of the queue. The table entry for that destination is then pointed at the new register. A separate release port appends a retired physical register to the tail of the queue.

The lookups and the head of the queue appear on the outputs combinationally in the cycle the names are presented. The table update and the queue pop take effect at the next rising clock edge, so the sources of an instruction always see the mapping from before its own destination update. The free queue is controlled by a three-state occupancy machine:

- States: `FL_EMPTY`, `FL_PARTIAL`, `FL_FULL`.
- Transitions:
  - *fill_first*: `FL_EMPTY` to `FL_PARTIAL` on a push.
  - *drain_last*: `FL_PARTIAL` to `FL_EMPTY` on a pop with no push and one entry left.
  - *fill_last*: `FL_PARTIAL` to `FL_FULL` on a push with no pop and one slot left.
  - *drain_first*: `FL_FULL` to `FL_PARTIAL` on a pop with no push.

Reset places the machine in `FL_PARTIAL`. With the default sizes there are 8 architectural names and 16 physical registers.

Top module: `map_renamer`

## Requirements
- R1: After reset, a lookup of architectural register i returns physical tag i, for every i.
- R2: After reset, the free queue holds tags NUM_ARCH to NUM_PHYS-1, and successive allocations receive them in ascending order (8, 9, ... 15 by default).
- R3: A renamed instruction with a destination points the table entry for that destination at the tag shown on `phys_dst`. Lookups of that name from the next cycle on return this tag.
- R4: Source lookups in the cycle of renaming return the mapping from before that instruction's own destination update. For example, r1 = r1 + r1 with r1 at tag 8 reads tag 8 on both sources and writes a fresh tag.
- R5: An instruction with `ren_has_dst` low consumes no free register and leaves the table unchanged.
- R6: When the free queue is empty and `ren_has_dst` is high, `ren_ready` is low. The instruction is not renamed: no table change and no pop.
- R7: An instruction without a destination is never stalled: `ren_ready` is high when `ren_has_dst` is low, even with an empty free queue.
- R8: A released tag joins the tail of the free queue and is handed out only after every tag that was free before it.
- R9: A release and an allocation in the same cycle both take effect. A release into an empty queue becomes allocatable from the next cycle on.
- R10: With `ren_valid` low, neither the table nor the free queue changes.
- R11: Two successive writes to the same architectural name receive distinct tags, and later lookups return the second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_has_dst | input | 1 | The instruction writes a destination register |
| ren_src_a | input | 3 | First source architectural name |
| ren_src_b | input | 3 | Second source architectural name |
| ren_dst | input | 3 | Destination architectural name |
| ren_ready | output | 1 | Renaming can proceed this cycle |
| phys_src_a | output | 4 | Physical tag for the first source |
| phys_src_b | output | 4 | Physical tag for the second source |
| phys_dst | output | 4 | Physical tag allocated to the destination (free-queue head) |
| rel_valid | input | 1 | A physical register is being released |
| rel_tag | input | 4 | Physical tag being released |

## Verification
The bench targets the case where an instruction reads the very name it writes. A design that forwarded the new tag to its own sources would break the r1 = r1 + r1 rows. It drains the queue to empty and then stalls a writing instruction. An implementation that popped anyway, or that updated the table while stalled, would hand out stale tags or corrupt the entry that later rows read back. It releases a tag while allocating, and also while the queue is empty and stalled. A design that dropped either action, or bypassed the release into the same cycle, would give the wrong tag on the following row. Tags handed out after a release show whether the freed tag went to the tail or jumped the queue.

// File: rtl/renamer_pkg.sv
package renamer_pkg;
    localparam int NUM_ARCH_DEF = 8;
    localparam int NUM_PHYS_DEF = 16;

    typedef enum logic [1:0] {
        FL_EMPTY,
        FL_PARTIAL,
        FL_FULL
    } fl_state_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_ARCH = renamer_pkg::NUM_ARCH_DEF,
    parameter int NUM_PHYS = renamer_pkg::NUM_PHYS_DEF,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    output logic [TW-1:0] tag_a,
    output logic [TW-1:0] tag_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag
);
    logic [TW-1:0] entry [NUM_ARCH];

    // One register per architectural name, reset to the identity mapping.
    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[g] <= TW'(g);
            end else if (wr_en && (wr_idx == AW'(g))) begin
                entry[g] <= wr_tag;
            end
        end
    end

    // Reads see the stored mapping, never the write of this cycle.
    assign tag_a = entry[rd_a];
    assign tag_b = entry[rd_b];
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
    import renamer_pkg::*;
#(
    parameter int NUM_ARCH = renamer_pkg::NUM_ARCH_DEF,
    parameter int NUM_PHYS = renamer_pkg::NUM_PHYS_DEF,
    localparam int DEPTH = NUM_PHYS,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int TW = $clog2(NUM_PHYS),
    localparam int INIT_FREE = NUM_PHYS - NUM_ARCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    output logic [TW-1:0] head_tag,
    output logic          empty,
    output logic          full
);
    fl_state_e     state, state_nxt;
    logic [TW-1:0] slot [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop, do_push;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    // Transition logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            FL_EMPTY: begin
                if (do_push) state_nxt = FL_PARTIAL;                        // fill_first
            end
            FL_PARTIAL: begin
                if (do_push && !do_pop && cnt_q == CW'(DEPTH - 1))
                    state_nxt = FL_FULL;                                     // fill_last
                else if (do_pop && !do_push && cnt_q == CW'(1))
                    state_nxt = FL_EMPTY;                                    // drain_last
            end
            FL_FULL: begin
                if (do_pop && !do_push) state_nxt = FL_PARTIAL;              // drain_first
            end
            default: state_nxt = FL_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FL_PARTIAL;
        else        state <= state_nxt;
    end

    // Outputs decoded from the state.
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state)
            FL_EMPTY:   empty = 1'b1;
            FL_PARTIAL: ;
            FL_FULL:    full  = 1'b1;
            default:    empty = 1'b1;
        endcase
    end

    // Queue storage and pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                slot[i] <= (i < INIT_FREE) ? TW'(NUM_ARCH + i) : '0;
            head_q <= '0;
            tail_q <= PW'(INIT_FREE);
            cnt_q  <= CW'(INIT_FREE);
        end else begin
            if (do_push) begin
                slot[tail_q] <= push_tag;
                tail_q       <= step(tail_q);
            end
            if (do_pop) head_q <= step(head_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign head_tag = slot[head_q];
endmodule

// File: rtl/map_renamer.sv
module map_renamer #(
    parameter int NUM_ARCH = renamer_pkg::NUM_ARCH_DEF,
    parameter int NUM_PHYS = renamer_pkg::NUM_PHYS_DEF,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic          ren_has_dst,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    input  logic [AW-1:0] ren_dst,
    output logic          ren_ready,
    output logic [TW-1:0] phys_src_a,
    output logic [TW-1:0] phys_src_b,
    output logic [TW-1:0] phys_dst,
    input  logic          rel_valid,
    input  logic [TW-1:0] rel_tag
);
    logic fl_empty, fl_full, alloc;

    // Only a write needs a free register; reads never stall.
    assign ren_ready = !(ren_has_dst && fl_empty);
    assign alloc     = ren_valid && ren_ready && ren_has_dst;

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_a   (ren_src_a),
        .rd_b   (ren_src_b),
        .tag_a  (phys_src_a),
        .tag_b  (phys_src_b),
        .wr_en  (alloc),
        .wr_idx (ren_dst),
        .wr_tag (phys_dst)
    );

    rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (rel_valid),
        .push_tag (rel_tag),
        .head_tag (phys_dst),
        .empty    (fl_empty),
        .full     (fl_full)
    );
endmodule

// File: rtl/map_renamer_checker.sv
module map_renamer_checker #(
    parameter int AW = 3,
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid,
    input logic          ren_has_dst,
    input logic [AW-1:0] ren_src_a,
    input logic [AW-1:0] ren_dst,
    input logic          ren_ready,
    input logic [TW-1:0] phys_src_a,
    input logic [TW-1:0] phys_dst,
    input logic          rel_valid,
    input logic          fl_empty
);
    logic alloc_seen;
    assign alloc_seen = ren_valid && ren_ready && ren_has_dst;

    // R3: the written name reads back the tag it was given.
    assert_map_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_seen |=> ((ren_src_a != $past(ren_dst)) || (phys_src_a == $past(phys_dst))));

    // R6: a stalled write pops nothing.
    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_has_dst && !ren_ready && !rel_valid) |=> $stable(phys_dst));

    // R7: an instruction without a destination is never stalled.
    assert_no_dst_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_has_dst |-> ren_ready);

    // R5, R10: no allocation and no release leave the queue head unchanged.
    assert_idle_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ren_valid || !ren_has_dst) && !rel_valid) |=> $stable(phys_dst));

    // R11: consecutive allocations give different tags.
    assert_fresh_tag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_seen |=> (fl_empty || (phys_dst != $past(phys_dst))));
endmodule

bind map_renamer map_renamer_checker #(.AW(AW), .TW(TW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ren_valid   (ren_valid),
    .ren_has_dst (ren_has_dst),
    .ren_src_a   (ren_src_a),
    .ren_dst     (ren_dst),
    .ren_ready   (ren_ready),
    .phys_src_a  (phys_src_a),
    .phys_dst    (phys_dst),
    .rel_valid   (rel_valid),
    .fl_empty    (fl_empty)
);

// File: tb/sim_map_renamer.sv
module sim_map_renamer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0, ren_has_dst = 1'b0;
    logic [2:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic       ren_ready;
    logic [3:0] phys_src_a, phys_src_b, phys_dst;
    logic       rel_valid = 1'b0;
    logic [3:0] rel_tag = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    map_renamer u0 (.*);

    typedef struct packed {
        logic       v;
        logic       hd;
        logic [2:0] sa;
        logic [2:0] sb;
        logic [2:0] d;
        logic       rv;
        logic [3:0] rt;
        logic       erdy;
        logic [3:0] esa;
        logic [3:0] esb;
        logic       chkd;
        logic [3:0] ed;
    } vec_t;

    // v hd sa sb d rv rt | rdy esa esb chkd ed
    localparam vec_t TBL [15] = '{
        '{1,1,1,2,1, 0,0,  1, 1, 2, 1, 8},   // R2 R1 first write r1
        '{1,1,1,1,1, 0,0,  1, 8, 8, 1, 9},   // R4 r1=r1+r1
        '{1,0,1,3,0, 0,0,  1, 9, 3, 1,10},   // R5 no destination
        '{1,1,2,1,2, 0,0,  1, 2, 9, 1,10},   // R5 head unchanged, R3
        '{0,1,2,0,2, 0,0,  1,10, 0, 1,11},   // R10 not valid
        '{1,1,2,2,3, 1,1,  1,10,10, 1,11},   // R10 r2 kept, R9 release+alloc
        '{1,1,3,0,0, 0,0,  1,11, 0, 1,12},   // R3
        '{1,1,4,4,4, 0,0,  1, 4, 4, 1,13},
        '{1,1,5,6,5, 0,0,  1, 5, 6, 1,14},
        '{1,1,6,7,6, 0,0,  1, 6, 7, 1,15},
        '{1,1,0,7,7, 0,0,  1,12, 7, 1, 1},   // R8 released tag after the rest
        '{1,1,7,1,1, 0,0,  0, 1, 9, 0, 0},   // R6 empty: stall
        '{1,0,3,7,0, 0,0,  1,11, 1, 0, 0},   // R7 ready without dst, R6 r1 kept
        '{1,1,7,1,1, 1,8,  0, 1, 9, 0, 0},   // R9 release into empty, still stalled
        '{1,1,1,1,1, 0,0,  1, 9, 9, 1, 8}    // R9 released tag now allocated
    };

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ren_valid = 0; ren_has_dst = 0; rel_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one instruction at a negedge; check at #1; commit at the next posedge.
    task automatic rename(input bit v, input bit hd, input int sa, input int sb, input int d);
        ren_valid = v; ren_has_dst = hd;
        ren_src_a = 3'(sa); ren_src_b = 3'(sb); ren_dst = 3'(d);
        #1;
    endtask

    initial begin
        do_reset();
        // R1: identity mapping for all names.
        for (int i = 0; i < 8; i++) begin
            rename(0, 0, i, 7 - i, 0);
            chk("R1 src_a", phys_src_a, i);
            chk("R1 src_b", phys_src_b, 7 - i);
            @(negedge clk);
        end

        do_reset();
        for (int k = 0; k < 15; k++) begin
            rename(TBL[k].v, TBL[k].hd, TBL[k].sa, TBL[k].sb, TBL[k].d);
            rel_valid = TBL[k].rv; rel_tag = TBL[k].rt;
            #1;
            chk($sformatf("row%0d ready", k), ren_ready, TBL[k].erdy);
            chk($sformatf("row%0d src_a", k), phys_src_a, TBL[k].esa);
            chk($sformatf("row%0d src_b", k), phys_src_b, TBL[k].esb);
            if (TBL[k].chkd) chk($sformatf("row%0d dst", k), phys_dst, TBL[k].ed);
            @(negedge clk);
            rel_valid = 0;
        end

        // R2: allocations after reset run 8..15 in order.
        do_reset();
        for (int i = 0; i < 8; i++) begin
            rename(1, 1, 0, 0, i);
            chk("R2 alloc order", phys_dst, 8 + i);
            @(negedge clk);
        end
        rename(1, 1, 0, 0, 0);
        chk("R6 empty after 8 allocs", ren_ready, 0);
        @(negedge clk);

        // R11: two writes to r5 get distinct tags; the later is visible.
        do_reset();
        rename(1, 1, 5, 5, 5);
        chk("R11 first tag", phys_dst, 8);
        @(negedge clk);
        rename(1, 1, 5, 5, 5);
        chk("R11 reads first tag", phys_src_a, 8);
        chk("R11 second tag", phys_dst, 9);
        @(negedge clk);
        rename(0, 0, 5, 4, 0);
        chk("R11 latest mapping", phys_src_a, 9);
        chk("R11 other name intact", phys_src_b, 4);
        @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule